// File: doc/BRIEF.md
# Interrupt Routing Table Controller

This block takes a set of peripheral interrupt lines and steers each one to any subset of CPU targets. A target is one hardware thread on one core. Every source owns a two-word routing entry. The first word is a destination mask with one bit per target. The second word holds an enable flag and a trigger-type flag. Edge-type sources latch a pending bit on a rising input, and the bit stays set until software acknowledges it. Level-type sources track their input. Each target's interrupt line is the OR of every enabled pending source whose mask selects that target.

Software reaches the block through a plain register port: a write strobe, a read strobe, an address and write data, with read data returned one cycle later. A write to the acknowledge offset clears pending bits one-for-one. A write to the inter-processor offset raises a one-cycle pulse on a single addressed target and publishes a six-bit message number. The port has no back-pressure: every strobe is taken in the cycle it is presented, so it carries no valid/ready handshake.

Top module: `intr_route_ctrl`

## Requirements
- R1: Out of reset, all destination masks, entry flags and pending bits are zero, `tgt_irq` and `ipi_pulse` are zero, and `reg_rdata` is zero.
- R2: The mask of source n is written and read at offset 0x40+n. The flag word of source n is at offset 0x80+n. In the flag word, bit 31 is enable and bit 30 is level mode, and a read returns only those two bits, with all other bits zero. Read data appears on `reg_rdata` in the cycle after `reg_rd` and holds until the next read. A read of a register in the same cycle it is written returns the old value. Unmapped offsets read as zero.
- R3: An enabled source in edge mode (bit 30 clear) sets its pending bit when its input is 0 at one clock edge and 1 at the next. The bit stays set after the input falls, until it is acknowledged.
- R4: An enabled source in level mode (bit 30 set) has a pending bit equal to its input as sampled at the previous clock edge. An acknowledge has no lasting effect on it.
- R5: Sources 1 through 8 always behave as edge type, whatever the value of bit 30.
- R6: A write to offset 0x06 clears the pending bit of every source n for which bit n of the data is 1. Other pending bits are left alone. A rising edge in the same cycle wins over the clear. A read of offset 0x06 returns the pending vector, with source n at bit n.
- R7: In the cycle after a pending bit is set, `tgt_irq[t]` is 1 exactly when some enabled source with a pending bit has bit t set in its mask.
- R8: While bit 31 of a source's flag word is clear, the source causes no target interrupt. Its edges are not latched, and its level is not tracked. Its mask and flag words still accept writes.
- R9: A write to offset 0x04 gives, in the next cycle only, a pulse on `ipi_pulse[core*4+thread]`. The core is taken from data bits 22:20 and the thread from bits 17:16. `ipi_num` takes data bits 5:0 and holds them until the next such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 32 | Peripheral interrupt lines, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| tgt_irq | output | 32 | Interrupt line per target (core*4+thread) |
| ipi_pulse | output | 32 | One-cycle inter-processor pulse per target |
| ipi_num | output | 6 | Message number of the last inter-processor write |

## Verification
A wrong pending bit shows on `tgt_irq` in the very next cycle for any target its mask selects, and on a read of offset 0x06 one cycle after the read strobe. A corrupted mask or flag bit is exposed by the next edge on that source, or at once if that source is already pending. Register readback exposes it two cycles after the write. A bad inter-processor decode shows as a pulse on the wrong target, or a pulse that lasts two cycles, in the cycle after the write. The random traffic mixes all of these with directed edge/level, forced-edge and acknowledge-collision cases.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned OFF_IPI     = 'h04;
  localparam int unsigned OFF_ACK     = 'h06;
  localparam int unsigned OFF_MASK    = 'h40;
  localparam int unsigned OFF_CTRL    = 'h80;
  localparam int unsigned EN_BIT      = 31;
  localparam int unsigned LVL_BIT     = 30;
  localparam int unsigned IPI_CORE_LSB = 20;
  localparam int unsigned IPI_THR_LSB  = 16;
  localparam int unsigned IPI_NUM_W    = 6;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_MASK = 2'd1,
    ACC_CTRL = 2'd2
  } acc_kind_t;
endpackage

// File: rtl/irc_regfile.sv
module irc_regfile
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_TGT = 32,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr,
  input  logic                             reg_rd,
  input  logic [ADDR_W-1:0]                reg_addr,
  input  logic [DATA_W-1:0]                reg_wdata,
  input  logic [NUM_SRC-1:0]               pend_vec,
  output logic [NUM_SRC-1:0][NUM_TGT-1:0]  mask_arr,
  output logic [NUM_SRC-1:0]               en_vec,
  output logic [NUM_SRC-1:0]               lvl_vec,
  output logic [NUM_SRC-1:0]               ack_vec,
  output logic                             ipi_wr,
  output logic [DATA_W-1:0]                reg_rdata
);
  localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_IPI = ADDR_W'(OFF_IPI);

  logic [DATA_W-1:0] rd_val;

  assign ack_vec = (reg_wr && reg_addr == A_ACK) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign ipi_wr  = reg_wr && (reg_addr == A_IPI);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_entry
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK + s);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL + s);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_arr[s] <= '0;
        en_vec[s]   <= 1'b0;
        lvl_vec[s]  <= 1'b0;
      end else if (reg_wr) begin
        if (reg_addr == A_MASK) mask_arr[s] <= reg_wdata[NUM_TGT-1:0];
        if (reg_addr == A_CTRL) begin
          en_vec[s]  <= reg_wdata[EN_BIT];
          lvl_vec[s] <= reg_wdata[LVL_BIT];
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == A_ACK) rd_val = DATA_W'(pend_vec);
    for (int s = 0; s < NUM_SRC; s++) begin
      if (reg_addr == ADDR_W'(OFF_MASK + s)) rd_val = DATA_W'(mask_arr[s]);
      if (reg_addr == ADDR_W'(OFF_CTRL + s)) begin
        rd_val = '0;
        rd_val[EN_BIT]  = en_vec[s];
        rd_val[LVL_BIT] = lvl_vec[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/irc_pending.sv
module irc_pending #(
  parameter int unsigned NUM_SRC       = 32,
  parameter int unsigned FORCE_EDGE_LO = 1,
  parameter int unsigned FORCE_EDGE_HI = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic [NUM_SRC-1:0] en_vec,
  input  logic [NUM_SRC-1:0] lvl_vec,
  input  logic [NUM_SRC-1:0] ack_vec,
  output logic [NUM_SRC-1:0] edge_vec,
  output logic [NUM_SRC-1:0] pend_vec
);
  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] pend_n;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam bit FORCED = (s >= FORCE_EDGE_LO) && (s <= FORCE_EDGE_HI);
    logic rise;
    assign edge_vec[s] = FORCED | ~lvl_vec[s];
    assign rise        = src_in[s] & ~src_q[s] & en_vec[s];
    always_comb begin
      if (edge_vec[s]) pend_n[s] = (pend_vec[s] & ~ack_vec[s]) | rise;
      else             pend_n[s] = src_in[s] & en_vec[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      pend_vec <= '0;
    end else begin
      src_q    <= src_in;
      pend_vec <= pend_n;
    end
  end
endmodule

// File: rtl/irc_fanout.sv
module irc_fanout #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_TGT = 32
) (
  input  logic [NUM_SRC-1:0]              pend_vec,
  input  logic [NUM_SRC-1:0]              en_vec,
  input  logic [NUM_SRC-1:0][NUM_TGT-1:0] mask_arr,
  output logic [NUM_TGT-1:0]              tgt_irq
);
  logic [NUM_SRC-1:0] live;
  assign live = pend_vec & en_vec;

  always_comb begin
    tgt_irq = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (live[s]) tgt_irq = tgt_irq | mask_arr[s];
    end
  end
endmodule

// File: rtl/irc_ipi.sv
module irc_ipi #(
  parameter int unsigned NUM_CORE   = 8,
  parameter int unsigned NUM_THREAD = 4,
  parameter int unsigned CORE_W     = 3,
  parameter int unsigned THR_W      = 2,
  parameter int unsigned NUM_W      = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ipi_wr,
  input  logic [CORE_W-1:0]                core_sel,
  input  logic [THR_W-1:0]                 thr_sel,
  input  logic [NUM_W-1:0]                 num_in,
  output logic [NUM_CORE*NUM_THREAD-1:0]   ipi_pulse,
  output logic [NUM_W-1:0]                 ipi_num
);
  localparam int unsigned NUM_TGT = NUM_CORE * NUM_THREAD;
  localparam int unsigned IDX_W   = CORE_W + THR_W + 1;

  logic [IDX_W-1:0]   tgt_idx;
  logic [NUM_TGT-1:0] pulse_n;

  assign tgt_idx = IDX_W'(core_sel) * IDX_W'(NUM_THREAD) + IDX_W'(thr_sel);

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    assign pulse_n[t] = ipi_wr && (tgt_idx == IDX_W'(t));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipi_pulse <= '0;
      ipi_num   <= '0;
    end else begin
      ipi_pulse <= pulse_n;
      if (ipi_wr) ipi_num <= num_in;
    end
  end
endmodule

// File: rtl/intr_route_ctrl.sv
module intr_route_ctrl
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC       = 32,
  parameter int unsigned NUM_CORE      = 8,
  parameter int unsigned NUM_THREAD    = 4,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned FORCE_EDGE_LO = 1,
  parameter int unsigned FORCE_EDGE_HI = 8,
  localparam int unsigned NUM_TGT      = NUM_CORE * NUM_THREAD,
  localparam int unsigned CORE_W       = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
  localparam int unsigned THR_W        = (NUM_THREAD > 1) ? $clog2(NUM_THREAD) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_in,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_TGT-1:0]   tgt_irq,
  output logic [NUM_TGT-1:0]   ipi_pulse,
  output logic [IPI_NUM_W-1:0] ipi_num
);
  logic [NUM_SRC-1:0][NUM_TGT-1:0] mask_arr;
  logic [NUM_SRC-1:0] en_vec;
  logic [NUM_SRC-1:0] lvl_vec;
  logic [NUM_SRC-1:0] ack_vec;
  logic [NUM_SRC-1:0] edge_vec;
  logic [NUM_SRC-1:0] pend_vec;
  logic               ipi_wr;

  irc_regfile #(
    .NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend_vec(pend_vec),
    .mask_arr(mask_arr), .en_vec(en_vec), .lvl_vec(lvl_vec),
    .ack_vec(ack_vec), .ipi_wr(ipi_wr), .reg_rdata(reg_rdata)
  );

  irc_pending #(
    .NUM_SRC(NUM_SRC), .FORCE_EDGE_LO(FORCE_EDGE_LO), .FORCE_EDGE_HI(FORCE_EDGE_HI)
  ) u_pend (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .en_vec(en_vec),
    .lvl_vec(lvl_vec), .ack_vec(ack_vec), .edge_vec(edge_vec), .pend_vec(pend_vec)
  );

  irc_fanout #(
    .NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT)
  ) u_fan (
    .pend_vec(pend_vec), .en_vec(en_vec), .mask_arr(mask_arr), .tgt_irq(tgt_irq)
  );

  irc_ipi #(
    .NUM_CORE(NUM_CORE), .NUM_THREAD(NUM_THREAD),
    .CORE_W(CORE_W), .THR_W(THR_W), .NUM_W(IPI_NUM_W)
  ) u_ipi (
    .clk(clk), .rst_n(rst_n), .ipi_wr(ipi_wr),
    .core_sel(reg_wdata[IPI_CORE_LSB +: CORE_W]),
    .thr_sel(reg_wdata[IPI_THR_LSB +: THR_W]),
    .num_in(reg_wdata[IPI_NUM_W-1:0]),
    .ipi_pulse(ipi_pulse), .ipi_num(ipi_num)
  );
endmodule

// File: rtl/irc_checker.sv
module irc_checker
  import irc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned NUM_TGT = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [NUM_SRC-1:0] src_in,
  input logic [NUM_SRC-1:0] en_vec,
  input logic [NUM_SRC-1:0] edge_vec,
  input logic [NUM_SRC-1:0] pend_vec,
  input logic [NUM_TGT-1:0] tgt_irq,
  input logic [NUM_TGT-1:0] ipi_pulse
);
  logic [NUM_SRC-1:0] ack_seen;
  logic               ipi_seen;
  assign ack_seen = (reg_wr && reg_addr == ADDR_W'(OFF_ACK)) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign ipi_seen = reg_wr && (reg_addr == ADDR_W'(OFF_IPI));

  // R3: a latched edge survives every cycle without an acknowledge
  a_r3_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend_vec & edge_vec & ~ack_seen) & edge_vec & ~pend_vec) == '0));

  // R4: level sources mirror the input sampled one edge earlier
  a_r4_level_track: assert property (@(posedge clk) disable iff (!rst_n)
    (((pend_vec ^ $past(src_in)) & $past(~edge_vec & en_vec)) == '0));

  // R8: with every entry disabled no target is interrupted
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_vec == '0) |-> (tgt_irq == '0));

  // R9: at most one target pulses at a time
  a_r9_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ipi_pulse));

  // R9: a pulse only follows a write to the inter-processor offset
  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ipi_seen) |-> (ipi_pulse == '0));
endmodule

bind intr_route_ctrl irc_checker #(.NUM_SRC(NUM_SRC), .NUM_TGT(NUM_TGT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .src_in(src_in), .en_vec(en_vec),
  .edge_vec(edge_vec), .pend_vec(pend_vec), .tgt_irq(tgt_irq),
  .ipi_pulse(ipi_pulse)
);

// File: tb/intr_route_ctrl_tb.sv
module intr_route_ctrl_tb;
  localparam int NS = 32;
  localparam int NT = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NS-1:0] src_in = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NT-1:0] tgt_irq, ipi_pulse;
  logic [5:0]    ipi_num;

  intr_route_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tgt_irq(tgt_irq), .ipi_pulse(ipi_pulse), .ipi_num(ipi_num)
  );

  // reference model
  logic [NT-1:0] m_mask [NS];
  logic [NS-1:0] m_en = '0, m_lvl = '0, m_pend = '0, m_prev = '0;
  logic [NT-1:0] m_pulse = '0;
  logic [5:0]    m_num = '0;
  logic [NS-1:0] src_nx = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [31:0] v = '0;
    if (a == 8'h06) v = m_pend;
    for (int s = 0; s < NS; s++) begin
      if (a == 8'(8'h40 + s)) v = m_mask[s];
      if (a == 8'(8'h80 + s)) v = {m_en[s], m_lvl[s], 30'd0};
    end
    return v;
  endfunction

  function automatic logic [NT-1:0] model_tgt();
    logic [NT-1:0] v = '0;
    for (int s = 0; s < NS; s++) if (m_pend[s] && m_en[s]) v |= m_mask[s];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [7:0] a,
                      input logic [31:0] d, input string tag);
    logic [31:0]   exp_rd;
    logic [NS-1:0] ack, rise;
    @(negedge clk);
    src_in = src_nx; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    exp_rd = model_read(a);
    ack  = (wr && a == 8'h06) ? d : '0;
    rise = src_nx & ~m_prev;
    for (int s = 0; s < NS; s++) begin
      if (!m_lvl[s] || (s >= 1 && s <= 8))
        m_pend[s] = (m_pend[s] & ~ack[s]) | (rise[s] & m_en[s]);
      else
        m_pend[s] = src_nx[s] & m_en[s];
    end
    m_prev = src_nx;
    m_pulse = '0;
    if (wr) begin
      for (int s = 0; s < NS; s++) begin
        if (a == 8'(8'h40 + s)) m_mask[s] = d;
        if (a == 8'(8'h80 + s)) begin m_en[s] = d[31]; m_lvl[s] = d[30]; end
      end
      if (a == 8'h04) begin
        m_pulse[int'(d[22:20]) * 4 + int'(d[17:16])] = 1'b1;
        m_num = d[5:0];
      end
    end
    @(posedge clk); #1;
    chk({tag, " tgt_irq"}, tgt_irq, model_tgt());
    chk({tag, " ipi_pulse"}, ipi_pulse, m_pulse);
    chk({tag, " ipi_num"}, 32'(ipi_num), 32'(m_num));
    if (rd) chk({tag, " rdata"}, reg_rdata, exp_rd);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 8'h00, 32'h0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < NS; s++) m_mask[s] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 tgt_irq", tgt_irq, '0);
    chk("R1 ipi_pulse", ipi_pulse, '0);
    chk("R1 rdata", reg_rdata, '0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b1, 8'h45, 0, "R1");
    step(1'b0, 1'b1, 8'h06, 0, "R1");

    // R2 readback and masking of flag bits
    step(1'b1, 1'b1, 8'h45, 32'hA5A5_0003, "R2");
    step(1'b0, 1'b1, 8'h45, 0, "R2");
    step(1'b1, 1'b0, 8'h85, 32'hFFFF_FFFF, "R2");
    step(1'b0, 1'b1, 8'h85, 0, "R2");
    step(1'b0, 1'b1, 8'h33, 0, "R2");

    // R3 edge source 20 to targets 0 and 7
    step(1'b1, 1'b0, 8'h54, 32'h0000_0081, "R3");
    step(1'b1, 1'b0, 8'h94, 32'h8000_0000, "R3");
    src_nx[20] = 1'b1; idle("R3");
    src_nx[20] = 1'b0; idle("R3"); idle("R3");
    step(1'b0, 1'b1, 8'h06, 0, "R3");
    step(1'b1, 1'b0, 8'h06, 32'h0010_0000, "R6");
    step(1'b0, 1'b1, 8'h06, 0, "R6");

    // R4 level source 21
    step(1'b1, 1'b0, 8'h55, 32'h0000_0100, "R4");
    step(1'b1, 1'b0, 8'h95, 32'hC000_0000, "R4");
    src_nx[21] = 1'b1; idle("R4"); idle("R4");
    step(1'b1, 1'b0, 8'h06, 32'h0020_0000, "R4");
    idle("R4");
    src_nx[21] = 1'b0; idle("R4"); idle("R4");

    // R5 source 3 forced edge despite level flag
    step(1'b1, 1'b0, 8'h43, 32'h0000_0002, "R5");
    step(1'b1, 1'b0, 8'h83, 32'hC000_0000, "R5");
    src_nx[3] = 1'b1; idle("R5");
    src_nx[3] = 1'b0; idle("R5"); idle("R5");
    step(1'b0, 1'b1, 8'h06, 0, "R5");

    // R6 rise collides with acknowledge: rise wins
    src_nx[3] = 1'b1;
    step(1'b1, 1'b0, 8'h06, 32'h0000_0008, "R6");
    src_nx[3] = 1'b0;
    step(1'b0, 1'b1, 8'h06, 0, "R6");
    step(1'b1, 1'b0, 8'h06, 32'hFFFF_FFFF, "R6");

    // R8 disabled entry 22 still writable, no interrupt
    step(1'b1, 1'b0, 8'h56, 32'hFFFF_FFFF, "R8");
    step(1'b1, 1'b0, 8'h96, 32'h0000_0000, "R8");
    src_nx[22] = 1'b1; idle("R8");
    src_nx[22] = 1'b0; idle("R8");
    step(1'b0, 1'b1, 8'h06, 0, "R8");
    step(1'b0, 1'b1, 8'h56, 0, "R8");

    // R9 inter-processor pulses
    step(1'b1, 1'b0, 8'h04, 32'h0052_002A, "R9");
    idle("R9");
    step(1'b1, 1'b0, 8'h04, 32'h0073_003F, "R9");
    step(1'b1, 1'b0, 8'h04, 32'h0000_0001, "R9");
    idle("R9");

    // R7 random traffic
    for (int i = 0; i < 3000; i++) begin
      int op;
      logic [7:0] a;
      src_nx ^= ($urandom & $urandom & $urandom);
      op = $urandom % 8;
      case (op)
        0: step(1'b1, 1'b0, 8'(8'h40 + $urandom % NS), $urandom, "R7");
        1: step(1'b1, 1'b0, 8'(8'h80 + $urandom % NS), $urandom, "R7");
        2: step(1'b1, 1'b0, 8'h06, $urandom & $urandom, "R7");
        3: step(1'b1, 1'b0, 8'h04, $urandom, "R9");
        4: begin
          a = ($urandom % 3 == 0) ? 8'h06 : 8'(((($urandom % 2) + 1) * 8'h40) + $urandom % NS);
          step(1'b0, 1'b1, a, 0, "R2");
        end
        default: idle("R7");
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule